// File: doc/BRIEF.md
# EPROM Fast-Programming Sequencer

This controller burns a parallel, word-wide EPROM with the pulse-and-verify algorithm. After a start request it raises the main-supply enable and then the programming-voltage enable. It then walks the array from the lowest address to the highest. For each address it asks a word source for the data to be stored. It reads the cell as it stands, and if the cell already holds the wanted value it moves on without pulsing. If the wanted value needs a 1 where the cell already holds a 0, it stops at once, because programming can only clear bits. Otherwise it drives address and data, lets them settle, and fires one timed active-low pulse on the chip enable. It then reads the word back with output enable low and chip enable high, and pulses again until the word matches or the pulse cap is reached.

Once every address is done, the programming voltage is dropped and the whole array is read back once more at normal supply and compared against the word source. The main supply is released last, and the result stays on `done`/`fail` until the next start. Pulse width and settle time are clock-cycle parameters, so a 100 µs pulse is `PULSE_CYC` = 12500 at 125 MHz, and a bench can shorten both.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `dev_dq_oe` are 0, `dev_ce_n` and `dev_oe_n` are 1, and both supply enables are 0.
- R2: `dev_vcc_en` rises exactly `SETUP_CYC` cycles before `dev_vpp_en` rises; `dev_vpp_en` falls before `dev_vcc_en` falls; `dev_vpp_en` is never high while `dev_vcc_en` is low; both are low whenever `done` is high.
- R3: Each program pulse holds `dev_ce_n` low for exactly `PULSE_CYC` cycles, with `dev_oe_n` high, `dev_vpp_en` high and `dev_dq_oe` high, and `dev_addr` and `dev_dq_out` unchanged during the pulse; `dev_dq_out` equals the word source data for that address.
- R4: Every read (`dev_oe_n` low) happens with `dev_ce_n` high and `dev_dq_oe` low.
- R5: A word whose current cell value already equals the requested data gets no pulse.
- R6: A word that fails verify is pulsed again, and a word that verifies on its Nth pulse for any N up to `MAX_PULSES` (default 25) is accepted.
- R7: If a word still fails verify after `MAX_PULSES` pulses, the run ends with `fail`=1, `fail_code`=1 and `fail_addr` = that address; no later address is pulsed.
- R8: If the requested data has a 1 in a bit where the cell reads 0, the run ends with `fail_code`=2 and `fail_addr` = that address, without a pulse on that address.
- R9: Addresses are programmed in ascending order from 0 to the last address.
- R10: After the last address the array is read back with `dev_vpp_en` low; the first mismatch ends the run with `fail_code`=3 and `fail_addr` = that address.
- R11: On completion `done` stays high until the next `start`; a clean run gives `fail`=0 and `fail_code`=0, and `fail` is never high without `done`. `start` while `done` is high begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (sampled when not busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Run finished with an error |
| fail_code | output | 2 | 0 none, 1 pulse cap, 2 needs a one, 3 final read-back mismatch |
| fail_addr | output | ADDR_W | Address of the error |
| src_addr | output | ADDR_W | Address whose data is requested from the word source |
| src_data | input | DATA_W | Word to store at `src_addr` (combinational answer) |
| dev_addr | output | ADDR_W | Device address |
| dev_dq_out | output | DATA_W | Data driven to the device |
| dev_dq_oe | output | 1 | Drive enable for `dev_dq_out` |
| dev_dq_in | input | DATA_W | Data read from the device |
| dev_ce_n | output | 1 | Chip enable, active low; low only for program pulses |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_vcc_en | output | 1 | Main-supply enable |
| dev_vpp_en | output | 1 | Programming-voltage enable |

## Verification
The hardest case to reach is a read-back mismatch in the final pass. Every word has already verified by then, so a correct device never produces one. The bench device model corrupts a chosen word at the moment the programming voltage drops, and the failure can only appear in the second pass. The pulse cap needs a cell that answers only after more than 25 pulses, and the exact-cap success needs one that answers on the 25th. The model therefore gives each word its own pulse count before the cell takes the data.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC_UP,
        ST_VPP_UP,
        ST_PRE_RD,
        ST_SET_UP,
        ST_PULSE,
        ST_VFY,
        ST_VPP_DN,
        ST_FIN_RD,
        ST_VCC_DN,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        FK_NONE      = 2'd0,
        FK_LIMIT     = 2'd1,
        FK_NEEDS_ONE = 2'd2,
        FK_FINAL     = 2'd3
    } fail_kind_e;

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] last,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (!expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eprom_pulse_ctr.sv
module eprom_pulse_ctr #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PC_W = $clog2(MAX_PULSES + 1);
    localparam logic [PC_W-1:0] CAP = PC_W'(MAX_PULSES);

    logic [PC_W-1:0] cnt_d, cnt_q;

    assign at_limit = (cnt_q == CAP);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && !at_limit)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eprom_word_check.sv
module eprom_word_check #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] want,
    input  logic [DATA_W-1:0] got,
    output logic              match,
    output logic              needs_one
);
    // A cell can only be pulled from 1 to 0; a wanted 1 over a stored 0 is lost.
    assign match     = (want == got);
    assign needs_one = |(want & ~got);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 12500,
    parameter int SETUP_CYC  = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        fail_code,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_dq_out,
    output logic              dev_dq_oe,
    input  logic [DATA_W-1:0] dev_dq_in,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              dev_vcc_en,
    output logic              dev_vpp_en
);
    localparam int LONGEST = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1) + 1;
    localparam logic [TMR_W-1:0]  PULSE_LAST = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  SETUP_LAST = TMR_W'(SETUP_CYC - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq;
        logic              dq_oe;
        logic              ce_n;
        logic              oe_n;
        logic              vcc_en;
        logic              vpp_en;
        logic              done;
        logic              fail;
        fail_kind_e        kind;
        logic [ADDR_W-1:0] faddr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_clr, tmr_exp;
    logic [TMR_W-1:0] tmr_last;
    logic             pc_clr, pc_inc, pc_at_limit;
    logic             word_match, word_needs_one;
    logic             at_last;

    assign tmr_last = (r_q.st == ST_PULSE) ? PULSE_LAST : SETUP_LAST;
    assign at_last  = (r_q.addr == LAST_ADDR);

    eprom_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .last    (tmr_last),
        .expired (tmr_exp)
    );

    eprom_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pc_clr),
        .inc      (pc_inc),
        .at_limit (pc_at_limit)
    );

    eprom_word_check #(.DATA_W(DATA_W)) u_check (
        .want      (src_data),
        .got       (dev_dq_in),
        .match     (word_match),
        .needs_one (word_needs_one)
    );

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        pc_clr  = 1'b0;
        pc_inc  = 1'b0;

        unique case (r_q.st)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    r_d.st    = ST_VCC_UP;
                    r_d.addr  = '0;
                    r_d.kind  = FK_NONE;
                    r_d.faddr = '0;
                    tmr_clr   = 1'b1;
                end
            end
            ST_VCC_UP: begin
                if (tmr_exp) begin
                    r_d.st  = ST_VPP_UP;
                    tmr_clr = 1'b1;
                end
            end
            ST_VPP_UP: begin
                if (tmr_exp) begin
                    r_d.st  = ST_PRE_RD;
                    tmr_clr = 1'b1;
                    pc_clr  = 1'b1;
                end
            end
            ST_PRE_RD: begin
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    if (word_needs_one) begin
                        r_d.kind  = FK_NEEDS_ONE;
                        r_d.faddr = r_q.addr;
                        r_d.st    = ST_VPP_DN;
                    end else if (word_match) begin
                        pc_clr = 1'b1;
                        if (at_last) begin
                            r_d.st = ST_VPP_DN;
                        end else begin
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.st   = ST_PRE_RD;
                        end
                    end else begin
                        r_d.dq = src_data;
                        r_d.st = ST_SET_UP;
                    end
                end
            end
            ST_SET_UP: begin
                if (tmr_exp) begin
                    r_d.st  = ST_PULSE;
                    pc_inc  = 1'b1;
                    tmr_clr = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    r_d.st  = ST_VFY;
                    tmr_clr = 1'b1;
                end
            end
            ST_VFY: begin
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    if (word_match) begin
                        pc_clr = 1'b1;
                        if (at_last) begin
                            r_d.st = ST_VPP_DN;
                        end else begin
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.st   = ST_PRE_RD;
                        end
                    end else if (pc_at_limit) begin
                        r_d.kind  = FK_LIMIT;
                        r_d.faddr = r_q.addr;
                        r_d.st    = ST_VPP_DN;
                    end else begin
                        r_d.dq = src_data;
                        r_d.st = ST_SET_UP;
                    end
                end
            end
            ST_VPP_DN: begin
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    if (r_q.kind != FK_NONE) begin
                        r_d.st = ST_VCC_DN;
                    end else begin
                        r_d.addr = '0;
                        r_d.st   = ST_FIN_RD;
                    end
                end
            end
            ST_FIN_RD: begin
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    if (!word_match) begin
                        r_d.kind  = FK_FINAL;
                        r_d.faddr = r_q.addr;
                        r_d.st    = ST_VCC_DN;
                    end else if (at_last) begin
                        r_d.st = ST_VCC_DN;
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
            end
            ST_VCC_DN: begin
                if (tmr_exp) begin
                    r_d.st  = ST_FINISH;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Device strobes are registered decodes of the next state.
        r_d.ce_n   = (r_d.st != ST_PULSE);
        r_d.oe_n   = !(r_d.st inside {ST_PRE_RD, ST_VFY, ST_FIN_RD});
        r_d.dq_oe  = (r_d.st inside {ST_SET_UP, ST_PULSE});
        r_d.vpp_en = (r_d.st inside {ST_VPP_UP, ST_PRE_RD, ST_SET_UP, ST_PULSE, ST_VFY});
        r_d.vcc_en = !(r_d.st inside {ST_IDLE, ST_VCC_DN, ST_FINISH});
        r_d.done   = (r_d.st == ST_FINISH);
        r_d.fail   = (r_d.st == ST_FINISH) && (r_d.kind != FK_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.kind   <= FK_NONE;
            r_q.ce_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE) && (r_q.st != ST_FINISH);
    assign done       = r_q.done;
    assign fail       = r_q.fail;
    assign fail_code  = r_q.kind;
    assign fail_addr  = r_q.faddr;
    assign src_addr   = r_q.addr;
    assign dev_addr   = r_q.addr;
    assign dev_dq_out = r_q.dq;
    assign dev_dq_oe  = r_q.dq_oe;
    assign dev_ce_n   = r_q.ce_n;
    assign dev_oe_n   = r_q.oe_n;
    assign dev_vcc_en = r_q.vcc_en;
    assign dev_vpp_en = r_q.vpp_en;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 12500,
    parameter int MAX_PULSES = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [1:0]        fail_code,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [DATA_W-1:0] dev_dq_out,
    input logic              dev_dq_oe,
    input logic              dev_ce_n,
    input logic              dev_oe_n,
    input logic              dev_vcc_en,
    input logic              dev_vpp_en
);
    localparam int LW = $clog2(PULSE_CYC + 2) + 1;
    localparam int PW = $clog2(MAX_PULSES + 2) + 1;

    logic [LW-1:0]     low_q;
    logic [PW-1:0]     here_q;
    logic [ADDR_W-1:0] addr_seen_q;
    logic              ce_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q       <= '0;
            here_q      <= '0;
            addr_seen_q <= '0;
            ce_prev_q   <= 1'b1;
        end else begin
            low_q     <= dev_ce_n ? '0 : low_q + 1'b1;
            ce_prev_q <= dev_ce_n;
            addr_seen_q <= dev_addr;
            if (dev_addr != addr_seen_q)
                here_q <= '0;
            else if (ce_prev_q && !dev_ce_n)
                here_q <= here_q + 1'b1;
        end
    end

    assert_vpp_under_vcc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_vpp_en |-> dev_vcc_en);

    assert_supplies_off_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dev_vpp_en && !dev_vcc_en));

    assert_pulse_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ce_n |-> (dev_oe_n && dev_vpp_en && dev_dq_oe));

    assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && ce_prev_q == 1'b0) |-> ($stable(dev_addr) && $stable(dev_dq_out)));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ce_n) |-> (low_q == LW'(PULSE_CYC)));

    assert_read_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (dev_ce_n && !dev_dq_oe));

    assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        here_q <= PW'(MAX_PULSES));

    assert_fail_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !busy));

    assert_clean_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (fail_code == 2'd0));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_code  (fail_code),
    .dev_addr   (dev_addr),
    .dev_dq_out (dev_dq_out),
    .dev_dq_oe  (dev_dq_oe),
    .dev_ce_n   (dev_ce_n),
    .dev_oe_n   (dev_oe_n),
    .dev_vcc_en (dev_vcc_en),
    .dev_vpp_en (dev_vpp_en)
);

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
module tb_eprom_prog_seq;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int PULSE = 10;
    localparam int SETUP = 3;
    localparam int MAXP  = 25;
    localparam int WORDS = 1 << AW;
    localparam int WDOG  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic [1:0]    fail_code;
    logic [AW-1:0] fail_addr, src_addr, dev_addr;
    logic [DW-1:0] src_data, dev_dq_out, dev_dq_in;
    logic          dev_dq_oe, dev_ce_n, dev_oe_n, dev_vcc_en, dev_vpp_en;

    always #4 clk = ~clk;

    // Scenario images, owned by the driver.
    logic [DW-1:0] target   [WORDS];
    logic [DW-1:0] init_img [WORDS];
    int            need     [WORDS];
    logic          do_load = 1'b0;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [DW-1:0] inj_mask = '1;

    // Device model state.
    logic [DW-1:0] mem  [WORDS];
    int            hits [WORDS];

    logic [DW+AW-1:0] exp_q [$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    assign src_data  = target[src_addr];
    assign dev_dq_in = dev_oe_n ? '1 : mem[dev_addr];

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP), .MAX_PULSES(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
        .fail_code(fail_code), .fail_addr(fail_addr), .src_addr(src_addr), .src_data(src_data),
        .dev_addr(dev_addr), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe), .dev_dq_in(dev_dq_in),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_vcc_en(dev_vcc_en), .dev_vpp_en(dev_vpp_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Device model: a cell takes the driven data once it has seen need[] pulses.
    logic ce_m = 1'b1, vpp_m = 1'b0;
    always @(negedge clk) begin
        if (do_load) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i]  = init_img[i];
                hits[i] = 0;
            end
        end else begin
            if (!ce_m && dev_ce_n) begin
                hits[dev_addr] = hits[dev_addr] + 1;
                if (hits[dev_addr] >= need[dev_addr])
                    mem[dev_addr] = mem[dev_addr] & dev_dq_out;
            end
            if (vpp_m && !dev_vpp_en && inj_en)
                mem[inj_addr] = mem[inj_addr] & inj_mask;
        end
        ce_m  = dev_ce_n;
        vpp_m = dev_vpp_en;
    end

    // Monitor: each pulse start pops the next expected (address, data).
    logic ce_s = 1'b1;
    int   low_cnt = 0;
    logic [DW+AW-1:0] item;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ce_s && !dev_ce_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected pulse at address", 32'(dev_addr), 32'hFFFF);
                end else begin
                    item = exp_q.pop_front();
                    chk(dev_addr == item[DW+AW-1:DW], "R9", "pulse address",
                        32'(dev_addr), 32'(item[DW+AW-1:DW]));
                    chk(dev_dq_out == item[DW-1:0], "R3", "pulse data",
                        32'(dev_dq_out), 32'(item[DW-1:0]));
                end
            end
            if (!dev_ce_n) begin
                low_cnt++;
                chk(dev_oe_n && dev_vpp_en && dev_dq_oe, "R3", "bus during pulse",
                    {29'd0, dev_oe_n, dev_vpp_en, dev_dq_oe}, 32'h7);
            end
            if (!ce_s && dev_ce_n) begin
                chk(low_cnt == PULSE, "R3", "pulse width", 32'(low_cnt), 32'(PULSE));
                low_cnt = 0;
            end
            if (!dev_oe_n && !dev_vpp_en && dev_vcc_en && ce_s && dev_ce_n && dev_dq_oe)
                chk(1'b0, "R4", "driving during read", 32'd1, 32'd0);
        end
        ce_s = dev_ce_n;
    end

    // Supply edge timestamps.
    logic vcc_t = 1'b0, vpp_t = 1'b0;
    int t_vcc_up, t_vpp_up, t_vpp_dn, t_vcc_dn;
    always @(negedge clk) begin
        if (!vcc_t && dev_vcc_en) t_vcc_up = cyc;
        if (!vpp_t && dev_vpp_en) t_vpp_up = cyc;
        if (vpp_t && !dev_vpp_en) t_vpp_dn = cyc;
        if (vcc_t && !dev_vcc_en) t_vcc_dn = cyc;
        vcc_t = dev_vcc_en;
        vpp_t = dev_vpp_en;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected done earlier", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver: derive expected pulses and the outcome from the scenario.
    int exp_code;
    int exp_faddr;
    task automatic plan_expect();
        logic [DW-1:0] after_prog;
        exp_code  = 0;
        exp_faddr = 0;
        for (int a = 0; a < WORDS; a++) begin
            if ((target[a] & ~init_img[a]) != 0) begin
                exp_code = 2; exp_faddr = a; return;
            end
            if (target[a] != init_img[a]) begin
                for (int p = 0; p < ((need[a] > MAXP) ? MAXP : need[a]); p++)
                    exp_q.push_back({AW'(a), target[a]});
                if (need[a] > MAXP) begin
                    exp_code = 1; exp_faddr = a; return;
                end
            end
        end
        if (inj_en) begin
            after_prog = target[inj_addr] & inj_mask;
            if (after_prog != target[inj_addr]) begin
                exp_code = 3; exp_faddr = int'(inj_addr);
            end
        end
    endtask

    task automatic run_case(input string name, input string req);
        @(negedge clk); do_load = 1'b1;
        @(negedge clk); do_load = 1'b0;
        plan_expect();
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done || busy) @(negedge clk);
        chk(fail == (exp_code != 0), req, {name, " fail flag"}, 32'(fail), 32'(exp_code != 0));
        chk(fail_code == 2'(exp_code), req, {name, " fail code"}, 32'(fail_code), 32'(exp_code));
        if (exp_code != 0)
            chk(fail_addr == AW'(exp_faddr), req, {name, " fail address"},
                32'(fail_addr), 32'(exp_faddr));
        chk(exp_q.size() == 0, req, {name, " pulses left unissued"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        chk(t_vpp_up - t_vcc_up == SETUP, "R2", {name, " supply-up spacing"},
            32'(t_vpp_up - t_vcc_up), 32'(SETUP));
        chk(t_vcc_dn > t_vpp_dn, "R2", {name, " supply-down order"},
            32'(t_vcc_dn), 32'(t_vpp_dn));
        repeat (5) @(negedge clk);
        chk(done && !busy, "R11", {name, " done held"}, {30'd0, done, busy}, 32'h2);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            target[i] = '1; init_img[i] = '1; need[i] = 1;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail, "R1", "reset flags", {29'd0, busy, done, fail}, 32'd0);
        chk(dev_ce_n && dev_oe_n && !dev_dq_oe, "R1", "reset strobes",
            {29'd0, dev_ce_n, dev_oe_n, dev_dq_oe}, 32'h6);
        chk(!dev_vcc_en && !dev_vpp_en, "R1", "reset supplies",
            {30'd0, dev_vcc_en, dev_vpp_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6: skips, retries and a word that takes exactly the pulse cap.
        target = '{16'hFFFF, 16'h1234, 16'hABCD, 16'hFFFF, 16'h0000, 16'hF0F0, 16'h7FFF, 16'hFFFE};
        init_img[5] = 16'hF0FF;
        need = '{1, 1, 3, 1, MAXP, 1, 2, 1};
        run_case("clean run", "R6");
        for (int a = 0; a < WORDS; a++)
            chk(mem[a] == target[a], "R5", "stored word", 32'(mem[a]), 32'(target[a]));

        // R7: one word never takes within the cap.
        for (int i = 0; i < WORDS; i++) begin
            target[i] = 16'h0000; init_img[i] = '1; need[i] = 1;
        end
        target[0] = 16'hAAAA; target[1] = 16'h5555; need[1] = MAXP + 1;
        run_case("pulse cap", "R7");
        chk(mem[2] == 16'hFFFF, "R7", "later word untouched", 32'(mem[2]), 32'hFFFF);

        // R8: a wanted one over a stored zero.
        for (int i = 0; i < WORDS; i++) begin
            target[i] = '1; init_img[i] = '1; need[i] = 1;
        end
        target[0] = 16'h0F0F; need[0] = 2;
        init_img[2] = 16'h00FF; target[2] = 16'h01FF;
        run_case("needs one", "R8");
        chk(mem[2] == 16'h00FF, "R8", "cell left alone", 32'(mem[2]), 32'h00FF);

        // R10: a word corrupted when the programming voltage drops.
        for (int i = 0; i < WORDS; i++) begin
            target[i] = 16'(16'h1111 * i); init_img[i] = '1; need[i] = 1;
        end
        inj_en = 1'b1; inj_addr = 3'd6; inj_mask = 16'hFFF0;
        run_case("final read-back", "R10");
        inj_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule